// File: doc/BRIEF.md
# Lane Ordered-Set Receive Classifier

This block sits on one lane of a serial link, after the 8b/10b decoder, and takes one decoded symbol per clock: an 8-bit byte and a flag that marks a control (K) symbol. On the receive side it recognises training sets of both kinds (TS1 and TS2) and the three short link-maintenance ordered sets (SKP, FTS and electrical idle). It reports each one to the link training state machine as a one-cycle pulse. It also keeps a saturating tally of TS1 sets received since the training state machine last changed state. It raises a flag while a run of at least eight D0.0 data symbols is in progress. It publishes the link and lane number fields of the most recent valid training set.

On the transmit side, the block forwards either link-layer data or the symbol stream built by the ordered-set generator. In the lane-number slot of an outgoing training set, it writes this lane's own index, or a PAD symbol when the lane has been disabled during link set-up.

The symbol codes are fixed: COM = K 0xBC, SKP = K 0x1C, FTS = K 0x3C, IDL = K 0x7C, PAD = K 0xF7, TS1 identifier = D 0x4A and TS2 identifier = D 0x45.

Top module: `lnos_lane`

## Requirements
- R1: A training set is COM followed by 15 symbols. Symbol 1 carries the link field, symbol 2 carries the lane field, and symbols 6 to 15 are all D 0x4A (TS1) or all D 0x45 (TS2). When such a set completes, `ts1_seen` or `ts2_seen` is high for exactly one cycle, the cycle after the last symbol is sampled.
- R2: A training set whose identifier symbols 6 to 15 are not all the same TS1 or TS2 data code is discarded. It gives no pulse, leaves `ts1_count` unchanged and leaves the published link and lane fields unchanged.
- R3: COM followed by three identical K symbols, each K 0x1C, K 0x3C or K 0x7C, pulses `skp_seen`, `fts_seen` or `idl_seen` respectively for one cycle, the cycle after the third symbol. At most one of the five pulse outputs is high in any cycle.
- R4: A symbol that breaks an ordered set aborts it with no report. A COM received at any point starts a new set, and after an abort nothing is recognised until the next COM.
- R5: `ts1_count` rises by one for each recognised TS1 set. It is cleared by a `state_chg` pulse. A TS1 set that completes in the same cycle as `state_chg` counts as the first of the new state, so the count becomes 1.
- R6: `ts1_count` saturates at 255 and stays there until `state_chg`.
- R7: `zero_run` is high from the cycle after the eighth consecutive D0.0 symbol (data 0x00, K flag clear), stays high while D0.0 symbols continue, and drops the cycle after any other symbol, including K 0x00.
- R8: `rx_link_num` and `rx_lane_num` take the symbol 1 and symbol 2 bytes of a recognised training set of either kind, in the same cycle as its pulse.
- R9: With `tx_sel_os` low, `tx_data` and `tx_k` give `tx_dl_data` and `tx_dl_k` one cycle later. `tx_lane_slot` and `tx_force_pad` have no effect in this case.
- R10: With `tx_sel_os` high, the outputs give `tx_os_data` and `tx_os_k` one cycle later. In a cycle with `tx_lane_slot` high, they instead carry data `lane_idx`, zero-extended, with K clear. If `tx_force_pad` is also high, they carry K 0xF7.
- R11: While `rst_n` is low, all pulses, `zero_run`, `ts1_count`, both published fields, `tx_data` and `tx_k` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received decoded symbol byte |
| rx_k | input | 1 | Received symbol is a control symbol |
| state_chg | input | 1 | Training state machine entered a new state |
| ts1_seen | output | 1 | TS1 set recognised (pulse) |
| ts2_seen | output | 1 | TS2 set recognised (pulse) |
| fts_seen | output | 1 | FTS ordered set recognised (pulse) |
| skp_seen | output | 1 | SKP ordered set recognised (pulse) |
| idl_seen | output | 1 | Electrical-idle ordered set recognised (pulse) |
| zero_run | output | 1 | Eight or more consecutive D0.0 symbols |
| ts1_count | output | CNT_W | TS1 sets since the last state change |
| rx_link_num | output | 8 | Link field of the last valid training set |
| rx_lane_num | output | 8 | Lane field of the last valid training set |
| lane_idx | input | LANE_W | This lane's number |
| tx_sel_os | input | 1 | Select ordered-set stream instead of link-layer data |
| tx_force_pad | input | 1 | Send PAD in the lane-number slot |
| tx_lane_slot | input | 1 | Current ordered-set symbol is the lane-number field |
| tx_dl_data | input | 8 | Link-layer data byte |
| tx_dl_k | input | 1 | Link-layer control flag |
| tx_os_data | input | 8 | Ordered-set generator byte |
| tx_os_k | input | 1 | Ordered-set generator control flag |
| tx_data | output | 8 | Transmit symbol byte |
| tx_k | output | 1 | Transmit control flag |

## Verification
The bench sends a training set that is correct in every position except one identifier symbol. A parser that checks only the first identifier would pulse and count it. It also sends a SKP set broken by an FTS symbol, one broken by a data symbol with the SKP byte, and one restarted by a second COM. A design that ignores the K flag, or that does not resynchronise on COM, would report the wrong set or none. The counter is driven to 255 with more TS1 sets than that to catch a wrap to zero. A state change is placed on the same cycle as a completing TS1 to catch a design that lets the clear drop that set. A K 0x00 symbol is placed inside a D0.0 run, and the lane slot is driven during link-layer pass-through, to catch decoders that ignore the flag or the select.

// File: rtl/lnos_pkg.sv
package lnos_pkg;

  localparam logic [7:0] K_COM  = 8'hBC;
  localparam logic [7:0] K_SKP  = 8'h1C;
  localparam logic [7:0] K_FTS  = 8'h3C;
  localparam logic [7:0] K_IDL  = 8'h7C;
  localparam logic [7:0] K_PAD  = 8'hF7;
  localparam logic [7:0] D_TS1  = 8'h4A;
  localparam logic [7:0] D_TS2  = 8'h45;

  localparam int POS_W    = 4;
  localparam int LANE_POS = 2;
  localparam int ID_FIRST = 6;
  localparam int TS_LAST  = 15;
  localparam int OS_LAST  = 3;

  typedef enum logic [1:0] {P_IDLE, P_FIRST, P_TS, P_OS} parse_st_t;

  function automatic logic is_os_code(input logic [7:0] d);
    return (d == K_SKP) || (d == K_FTS) || (d == K_IDL);
  endfunction

  function automatic logic is_ts_id(input logic [7:0] d);
    return (d == D_TS1) || (d == D_TS2);
  endfunction

  function automatic logic is_d00(input logic k, input logic [7:0] d);
    return !k && (d == 8'h00);
  endfunction

endpackage

// File: rtl/lnos_os_parse.sv
module lnos_os_parse
  import lnos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sym_d,
  input  logic       sym_k,
  output logic       hit_ts1,
  output logic       hit_ts2,
  output logic       hit_fts,
  output logic       hit_skp,
  output logic       hit_idl,
  output logic [7:0] cap_link,
  output logic [7:0] cap_lane
);

  parse_st_t        st, st_n;
  logic [POS_W-1:0] pos, pos_n;
  logic [7:0]       os_code, os_n, id_code, id_n, link_n, lane_n;

  always_comb begin
    st_n    = st;
    pos_n   = pos;
    os_n    = os_code;
    id_n    = id_code;
    link_n  = cap_link;
    lane_n  = cap_lane;
    hit_ts1 = 1'b0;
    hit_ts2 = 1'b0;
    hit_fts = 1'b0;
    hit_skp = 1'b0;
    hit_idl = 1'b0;
    if (sym_k && sym_d == K_COM) begin
      st_n  = P_FIRST;
      pos_n = POS_W'(1);
    end else begin
      case (st)
        P_FIRST: begin
          pos_n = POS_W'(2);
          if (sym_k && is_os_code(sym_d)) begin
            st_n = P_OS;
            os_n = sym_d;
          end else begin
            st_n   = P_TS;
            link_n = sym_d;
          end
        end
        P_TS: begin
          pos_n = pos + 1'b1;
          if (pos == POS_W'(LANE_POS)) begin
            lane_n = sym_d;
          end else if (pos == POS_W'(ID_FIRST)) begin
            if (!sym_k && is_ts_id(sym_d)) id_n = sym_d;
            else                           st_n = P_IDLE;
          end else if (pos > POS_W'(ID_FIRST)) begin
            if (sym_k || sym_d != id_code) begin
              st_n = P_IDLE;
            end else if (pos == POS_W'(TS_LAST)) begin
              st_n    = P_IDLE;
              hit_ts1 = (id_code == D_TS1);
              hit_ts2 = (id_code == D_TS2);
            end
          end
        end
        P_OS: begin
          if (sym_k && sym_d == os_code) begin
            pos_n = pos + 1'b1;
            if (pos == POS_W'(OS_LAST)) begin
              st_n    = P_IDLE;
              hit_skp = (os_code == K_SKP);
              hit_fts = (os_code == K_FTS);
              hit_idl = (os_code == K_IDL);
            end
          end else begin
            st_n = P_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      pos      <= '0;
      os_code  <= '0;
      id_code  <= '0;
      cap_link <= '0;
      cap_lane <= '0;
    end else begin
      st       <= st_n;
      pos      <= pos_n;
      os_code  <= os_n;
      id_code  <= id_n;
      cap_link <= link_n;
      cap_lane <= lane_n;
    end
  end

endmodule

// File: rtl/lnos_ts1_tally.sv
module lnos_ts1_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] next_count(
    input logic c, input logic i, input logic [CNT_W-1:0] cur);
    if (c)               return CNT_W'(i);
    else if (i && cur != TOP) return cur + 1'b1;
    else                 return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(clr, inc, count);
  end

endmodule

// File: rtl/lnos_zero_watch.sv
module lnos_zero_watch
  import lnos_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sym_d,
  input  logic       sym_k,
  output logic       run_hit
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!is_d00(sym_k, sym_d)) cnt <= '0;
    else if (cnt != LIMIT)       cnt <= cnt + 1'b1;
  end

  assign run_hit = (cnt == LIMIT);

endmodule

// File: rtl/lnos_tx_sel.sv
module lnos_tx_sel
  import lnos_pkg::*;
#(
  parameter int LANE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_idx,
  input  logic              sel_os,
  input  logic              force_pad,
  input  logic              lane_slot,
  input  logic [7:0]        dl_data,
  input  logic              dl_k,
  input  logic [7:0]        os_data,
  input  logic              os_k,
  output logic [7:0]        out_data,
  output logic              out_k
);

  logic [7:0] d_n;
  logic       k_n;

  always_comb begin
    if (!sel_os) begin
      d_n = dl_data;
      k_n = dl_k;
    end else if (lane_slot && force_pad) begin
      d_n = K_PAD;
      k_n = 1'b1;
    end else if (lane_slot) begin
      d_n = 8'(lane_idx);
      k_n = 1'b0;
    end else begin
      d_n = os_data;
      k_n = os_k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_k    <= 1'b0;
    end else begin
      out_data <= d_n;
      out_k    <= k_n;
    end
  end

endmodule

// File: rtl/lnos_lane.sv
module lnos_lane #(
  parameter int CNT_W   = 8,
  parameter int RUN_LEN = 8,
  parameter int LANE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_k,
  input  logic              state_chg,
  output logic              ts1_seen,
  output logic              ts2_seen,
  output logic              fts_seen,
  output logic              skp_seen,
  output logic              idl_seen,
  output logic              zero_run,
  output logic [CNT_W-1:0]  ts1_count,
  output logic [7:0]        rx_link_num,
  output logic [7:0]        rx_lane_num,
  input  logic [LANE_W-1:0] lane_idx,
  input  logic              tx_sel_os,
  input  logic              tx_force_pad,
  input  logic              tx_lane_slot,
  input  logic [7:0]        tx_dl_data,
  input  logic              tx_dl_k,
  input  logic [7:0]        tx_os_data,
  input  logic              tx_os_k,
  output logic [7:0]        tx_data,
  output logic              tx_k
);

  logic       ev_ts1, ev_ts2, ev_fts, ev_skp, ev_idl;
  logic [7:0] cap_link, cap_lane;

  lnos_os_parse u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_d    (rx_data),
    .sym_k    (rx_k),
    .hit_ts1  (ev_ts1),
    .hit_ts2  (ev_ts2),
    .hit_fts  (ev_fts),
    .hit_skp  (ev_skp),
    .hit_idl  (ev_idl),
    .cap_link (cap_link),
    .cap_lane (cap_lane)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ts1_seen, ts2_seen, fts_seen, skp_seen, idl_seen} <= '0;
      rx_link_num <= '0;
      rx_lane_num <= '0;
    end else begin
      {ts1_seen, ts2_seen, fts_seen, skp_seen, idl_seen} <=
        {ev_ts1, ev_ts2, ev_fts, ev_skp, ev_idl};
      if (ev_ts1 || ev_ts2) begin
        rx_link_num <= cap_link;
        rx_lane_num <= cap_lane;
      end
    end
  end

  lnos_ts1_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_chg),
    .inc   (ev_ts1),
    .count (ts1_count)
  );

  lnos_zero_watch #(.RUN_LEN(RUN_LEN)) u_zero (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_d   (rx_data),
    .sym_k   (rx_k),
    .run_hit (zero_run)
  );

  lnos_tx_sel #(.LANE_W(LANE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_idx  (lane_idx),
    .sel_os    (tx_sel_os),
    .force_pad (tx_force_pad),
    .lane_slot (tx_lane_slot),
    .dl_data   (tx_dl_data),
    .dl_k      (tx_dl_k),
    .os_data   (tx_os_data),
    .os_k      (tx_os_k),
    .out_data  (tx_data),
    .out_k     (tx_k)
  );

endmodule

// File: rtl/lnos_lane_chk.sv
module lnos_lane_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rx_data,
  input logic             rx_k,
  input logic             state_chg,
  input logic             ev_ts1,
  input logic             ts1_seen,
  input logic             ts2_seen,
  input logic             fts_seen,
  input logic             skp_seen,
  input logic             idl_seen,
  input logic             zero_run,
  input logic [CNT_W-1:0] ts1_count,
  input logic             tx_sel_os,
  input logic             tx_force_pad,
  input logic             tx_lane_slot,
  input logic [7:0]       tx_dl_data,
  input logic             tx_dl_k,
  input logic [7:0]       tx_data,
  input logic             tx_k
);

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ts1_seen || ts2_seen) |=> !(ts1_seen || ts2_seen));

  p_one_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ts1_seen, ts2_seen, fts_seen, skp_seen, idl_seen}));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_chg && !ev_ts1) |=> (ts1_count == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_chg && ev_ts1 && ts1_count != '1)
      |=> (ts1_count == CNT_W'($past(ts1_count) + 1'b1)));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_chg && ts1_count == '1) |=> (ts1_count == '1));

  p_zero_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_run |-> (!$past(rx_k) && $past(rx_data) == 8'h00));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sel_os |=> (tx_data == $past(tx_dl_data) && tx_k == $past(tx_dl_k)));

  p_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel_os && tx_lane_slot && tx_force_pad) |=> (tx_k && tx_data == 8'hF7));

endmodule

bind lnos_lane lnos_lane_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_data      (rx_data),
  .rx_k         (rx_k),
  .state_chg    (state_chg),
  .ev_ts1       (ev_ts1),
  .ts1_seen     (ts1_seen),
  .ts2_seen     (ts2_seen),
  .fts_seen     (fts_seen),
  .skp_seen     (skp_seen),
  .idl_seen     (idl_seen),
  .zero_run     (zero_run),
  .ts1_count    (ts1_count),
  .tx_sel_os    (tx_sel_os),
  .tx_force_pad (tx_force_pad),
  .tx_lane_slot (tx_lane_slot),
  .tx_dl_data   (tx_dl_data),
  .tx_dl_k      (tx_dl_k),
  .tx_data      (tx_data),
  .tx_k         (tx_k)
);

// File: tb/tb_lnos_lane.sv
`timescale 1ns/1ps
module tb_lnos_lane;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = 8'h7C;
  logic       rx_k = 1'b1;
  logic       state_chg = 1'b0;
  logic       ts1_seen, ts2_seen, fts_seen, skp_seen, idl_seen, zero_run;
  logic [7:0] ts1_count, rx_link_num, rx_lane_num;
  logic [4:0] lane_idx = 5'd0;
  logic       tx_sel_os = 1'b0, tx_force_pad = 1'b0, tx_lane_slot = 1'b0;
  logic [7:0] tx_dl_data = 8'h00, tx_os_data = 8'h00;
  logic       tx_dl_k = 1'b0, tx_os_k = 1'b0;
  logic [7:0] tx_data;
  logic       tx_k;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  lnos_lane dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_k(rx_k),
    .state_chg(state_chg), .ts1_seen(ts1_seen), .ts2_seen(ts2_seen),
    .fts_seen(fts_seen), .skp_seen(skp_seen), .idl_seen(idl_seen),
    .zero_run(zero_run), .ts1_count(ts1_count), .rx_link_num(rx_link_num),
    .rx_lane_num(rx_lane_num), .lane_idx(lane_idx), .tx_sel_os(tx_sel_os),
    .tx_force_pad(tx_force_pad), .tx_lane_slot(tx_lane_slot),
    .tx_dl_data(tx_dl_data), .tx_dl_k(tx_dl_k), .tx_os_data(tx_os_data),
    .tx_os_k(tx_os_k), .tx_data(tx_data), .tx_k(tx_k)
  );

  // {k, byte, expected {ts1, ts2, fts, skp, idl, zero_run}}
  localparam int NV = 37;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h1C, 6'b000000},
    {1'b1, 8'h1C, 6'b000000}, {1'b1, 8'h1C, 6'b000100},   // SKP  R3
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h3C, 6'b000000},
    {1'b1, 8'h3C, 6'b000000}, {1'b1, 8'h3C, 6'b001000},   // FTS  R3
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h7C, 6'b000000},
    {1'b1, 8'h7C, 6'b000000}, {1'b1, 8'h7C, 6'b000010},   // IDL  R3
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h1C, 6'b000000},
    {1'b1, 8'h3C, 6'b000000}, {1'b1, 8'h1C, 6'b000000},   // broken R4
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h1C, 6'b000000},
    {1'b0, 8'h1C, 6'b000000}, {1'b1, 8'h1C, 6'b000000},   // data byte R4
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h7C, 6'b000000},
    {1'b1, 8'hBC, 6'b000000}, {1'b1, 8'h1C, 6'b000000},
    {1'b1, 8'h1C, 6'b000000}, {1'b1, 8'h1C, 6'b000100},   // COM restart R4
    {1'b0, 8'h00, 6'b000000}, {1'b0, 8'h00, 6'b000000},
    {1'b0, 8'h00, 6'b000000}, {1'b0, 8'h00, 6'b000000},
    {1'b0, 8'h00, 6'b000000}, {1'b0, 8'h00, 6'b000000},
    {1'b0, 8'h00, 6'b000000}, {1'b0, 8'h00, 6'b000001},   // 8th D0.0 R7
    {1'b0, 8'h00, 6'b000001}, {1'b1, 8'h00, 6'b000000},   // K 0x00 breaks R7
    {1'b0, 8'h00, 6'b000000}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [7:0] d);
    rx_k = k;
    rx_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] pulses();
    return {ts1_seen, ts2_seen, fts_seen, skp_seen, idl_seen};
  endfunction

  // Training set; bad >= 6 corrupts that identifier symbol; clr raises
  // state_chg during the last symbol. Returns pulses after the last symbol.
  task automatic send_ts(input logic lk, input logic [7:0] link, input logic [7:0] lane,
                         input logic [7:0] id, input int bad, input logic clr,
                         output logic [4:0] seen);
    for (int i = 0; i < 16; i++) begin
      logic       k;
      logic [7:0] d;
      case (i)
        0: begin k = 1'b1; d = 8'hBC; end
        1: begin k = lk;   d = link;  end
        2: begin k = 1'b0; d = lane;  end
        3: begin k = 1'b0; d = 8'h10; end
        4: begin k = 1'b0; d = 8'h02; end
        5: begin k = 1'b0; d = 8'h01; end
        default: begin k = 1'b0; d = (i == bad) ? ((id == 8'h4A) ? 8'h45 : 8'h4A) : id; end
      endcase
      state_chg = clr && (i == 15);
      step(k, d);
    end
    state_chg = 1'b0;
    seen = pulses();
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [4:0] p;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 pulses in reset", {27'd0, pulses()}, 32'd0);
    chk("R11 count/zero in reset", {23'd0, zero_run, ts1_count}, 32'd0);
    chk("R11 fields/tx in reset", {7'd0, tx_k, tx_data, rx_link_num, rx_lane_num}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R7 vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13:6]);
      chk($sformatf("R3 R4 R7 vector %0d", i), {26'd0, pulses(), zero_run}, {26'd0, VEC[i][5:0]});
    end

    // R1 R5 R8 TS1
    send_ts(1'b0, 8'h05, 8'h02, 8'h4A, 0, 1'b0, p);
    chk("R1 TS1 pulse", {27'd0, p}, 32'b10000);
    chk("R5 count after TS1", {24'd0, ts1_count}, 32'd1);
    chk("R8 fields after TS1", {16'd0, rx_link_num, rx_lane_num}, 32'h0502);
    step(1'b1, 8'h7C);
    chk("R1 pulse lasts one cycle", {27'd0, pulses()}, 32'd0);

    // R1 R8 TS2 with PAD link field
    send_ts(1'b1, 8'hF7, 8'h03, 8'h45, 0, 1'b0, p);
    chk("R1 TS2 pulse", {27'd0, p}, 32'b01000);
    chk("R8 fields after TS2", {16'd0, rx_link_num, rx_lane_num}, 32'hF703);
    chk("R5 TS2 not counted", {24'd0, ts1_count}, 32'd1);

    // R2 one bad identifier symbol
    send_ts(1'b0, 8'h09, 8'h07, 8'h4A, 10, 1'b0, p);
    chk("R2 no pulse on bad set", {27'd0, p}, 32'd0);
    chk("R2 count unchanged", {24'd0, ts1_count}, 32'd1);
    chk("R2 fields unchanged", {16'd0, rx_link_num, rx_lane_num}, 32'hF703);
    send_ts(1'b0, 8'h09, 8'h07, 8'h45, 15, 1'b0, p);
    chk("R2 no pulse on bad last symbol", {27'd0, p}, 32'd0);

    // R5 clear and coincident clear
    state_chg = 1'b1;
    step(1'b1, 8'h7C);
    state_chg = 1'b0;
    chk("R5 cleared by state_chg", {24'd0, ts1_count}, 32'd0);
    send_ts(1'b0, 8'h01, 8'h01, 8'h4A, 0, 1'b0, p);
    send_ts(1'b0, 8'h01, 8'h01, 8'h4A, 0, 1'b1, p);
    chk("R5 coincident clear counts one", {24'd0, ts1_count}, 32'd1);

    // R6 saturation
    for (int n = 0; n < 260; n++) send_ts(1'b0, 8'h01, 8'h01, 8'h4A, 0, 1'b0, p);
    chk("R6 saturates at 255", {24'd0, ts1_count}, 32'd255);
    state_chg = 1'b1;
    step(1'b1, 8'h7C);
    state_chg = 1'b0;
    chk("R6 cleared after saturation", {24'd0, ts1_count}, 32'd0);

    // R9 R10 transmit
    lane_idx = 5'd5;
    tx_dl_data = 8'h5A; tx_dl_k = 1'b0; tx_os_data = 8'hBC; tx_os_k = 1'b1;
    tx_sel_os = 1'b0; tx_lane_slot = 1'b1; tx_force_pad = 1'b1;
    step(1'b1, 8'h7C);
    chk("R9 pass-through ignores slot and pad", {23'd0, tx_k, tx_data}, {23'd0, 1'b0, 8'h5A});
    tx_sel_os = 1'b1; tx_lane_slot = 1'b0; tx_force_pad = 1'b0;
    step(1'b1, 8'h7C);
    chk("R10 ordered-set symbol", {23'd0, tx_k, tx_data}, {23'd0, 1'b1, 8'hBC});
    tx_lane_slot = 1'b1;
    step(1'b1, 8'h7C);
    chk("R10 lane number slot", {23'd0, tx_k, tx_data}, {23'd0, 1'b0, 8'h05});
    tx_force_pad = 1'b1;
    step(1'b1, 8'h7C);
    chk("R10 forced PAD", {23'd0, tx_k, tx_data}, {23'd0, 1'b1, 8'hF7});

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule